// File: doc/BRIEF.md
# Single-Step Predictive Speed Controller

This block closes a speed loop with a receding-horizon predictive law, using signed fixed-point arithmetic throughout. On each sampling strobe it captures a measured speed and a speed setpoint. It then advances an internal first-order plant model by one sample and takes the gap between measurement and model as the disturbance estimate. Holding the previous drive value constant, it predicts the free response over a loadable number of future samples. From that prediction it computes the one least-squares correction that best removes the predicted tracking error.

The new drive value is the previous value plus that correction, clamped to the duty range of 0 to 100 percent. It appears together with a one-cycle completion pulse. A single shared multiplier steps through the horizon, and a sequential restoring divider forms the correction. The whole computation takes roughly a hundred clock cycles, far inside a millisecond-scale sampling period. The pole, gain and horizon length sit in small loadable registers.

Top module: `mpc_speed_ctrl`

## Requirements
- R1: After reset, `u_out` is 0, `busy` and `done` are low, and the model state, the previous drive and the disturbance estimate are all zero, so the first computation starts from a zero model.
- R2: All quantities are signed two's complement with F fraction bits (default F=12, W=24 bits). A scaled product p·q is (p·q) shifted arithmetically right by F (floor). Each stored W-bit quantity saturates to the W-bit range instead of wrapping. On each computation the model state advances as x = sat(a·x + sat(b·u_prev)).
- R3: With d = sat(meas − x) and the free response xf_0 = x, xf_k = sat(a·xf_{k−1} + sat(b·u_prev)), the predicted error at step k is e_k = sat(ref − sat(xf_k + d)), for k = 1 .. N2.
- R4: Step-response terms follow g_0 = 0, g_k = sat(a·g_{k−1} + b). The correction has magnitude floor((|Σ g_k·e_k| · 2^F) / Σ g_k²), limited to 2^(W−1)−1, and takes the sign of Σ g_k·e_k.
- R5: The new drive is u_prev + correction, clamped to the range 0 .. U_MAX (default 409600, which is 100.0 with F=12).
- R6: When Σ g_k² is zero (gain b = 0, or horizon N2 = 0), the drive stays unchanged while the model state and disturbance still advance.
- R7: Configuration writes use `cfg_sel` 0 for the pole a, 1 for the gain b and 2 for the horizon N2 (low bits of `cfg_data`); code 3 does nothing. The defaults are a = 3850 (≈0.94), b = 6308 (≈1.54) and N2 = 10.
- R8: The two W·W-wide sums Σ g·e and Σ g² saturate at the signed 2W-bit limits instead of wrapping.
- R9: A strobe that arrives while `busy` is high is ignored. A configuration write while `busy` is high is ignored.
- R10: `busy` rises the cycle after an accepted strobe and stays high until the cycle in which `done` pulses for one cycle. `u_out` changes only in a `done` cycle. The latency is at most 8 + 4·N2 + 2W + F cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strobe | input | 1 | Sampling pulse that starts a computation |
| meas | input | W | Measured speed, signed fixed-point |
| ref_spd | input | W | Speed setpoint, signed fixed-point |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Configuration target: 0 pole, 1 gain, 2 horizon |
| cfg_data | input | W | Configuration value |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse when a new drive value is presented |
| u_out | output | W | Drive (duty) command, signed fixed-point in 0 .. U_MAX |

## Verification
The assertions assume that strobes come as single-cycle pulses and that the horizon register never exceeds HMAX; the latency watch relies on both. The stimulus drives every strobe and configuration write for exactly one clock at the falling edge. It loads only horizons between 0 and 15, and it always waits for `done` before issuing the next intended strobe. The only overlapping strobes and writes are the deliberate ones that test the ignore rule.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_BU, ST_X, ST_XF, ST_G, ST_GE, ST_GG, ST_CHK, ST_DIV, ST_OUT
  } mpc_state_e;

  typedef enum logic [1:0] {
    SEL_POLE = 2'd0,
    SEL_GAIN = 2'd1,
    SEL_HOR  = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/mpc_cfg.sv
module mpc_cfg #(
  parameter int W        = 24,
  parameter int HW       = 4,
  parameter int A_INIT   = 3850,
  parameter int B_INIT   = 6308,
  parameter int HOR_INIT = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [1:0]          sel,
  input  logic [W-1:0]        data,
  output logic signed [W-1:0] coef_a,
  output logic signed [W-1:0] coef_b,
  output logic [HW-1:0]       hor
);
  import mpc_pkg::*;
  logic signed [W-1:0] a_d, b_d;
  logic [HW-1:0]       h_d;

  always_comb begin
    a_d = coef_a;
    b_d = coef_b;
    h_d = hor;
    if (we) begin
      case (cfg_sel_e'(sel))
        SEL_POLE: a_d = data;
        SEL_GAIN: b_d = data;
        SEL_HOR:  h_d = data[HW-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coef_a <= W'(A_INIT);
      coef_b <= W'(B_INIT);
      hor    <= HW'(HOR_INIT);
    end else begin
      coef_a <= a_d;
      coef_b <= b_d;
      hor    <= h_d;
    end
  end
endmodule

// File: rtl/mpc_qmul.sv
module mpc_qmul #(
  parameter int W = 24
) (
  input  logic signed [W-1:0]   op_a,
  input  logic signed [W-1:0]   op_b,
  output logic signed [2*W-1:0] prod
);
  assign prod = op_a * op_b;
endmodule

// File: rtl/mpc_divider.sv
module mpc_divider #(
  parameter int NW = 60,
  parameter int DW = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic [NW-1:0] quot,
  output logic          done
);
  localparam int CW = $clog2(NW + 1);

  logic [NW-1:0] q_q, q_d;
  logic [DW-1:0] r_q, r_d;
  logic [CW-1:0] n_q, n_d;
  logic          run_q, run_d, done_d;
  logic [DW:0]   trial, diff;

  always_comb begin
    q_d    = q_q;
    r_d    = r_q;
    n_d    = n_q;
    run_d  = run_q;
    done_d = 1'b0;
    trial  = {r_q, q_q[NW-1]};
    diff   = trial - {1'b0, divisor};
    if (start) begin
      q_d   = dividend;
      r_d   = '0;
      n_d   = CW'(NW);
      run_d = 1'b1;
    end else if (run_q) begin
      if (trial >= {1'b0, divisor}) begin
        r_d = diff[DW-1:0];
        q_d = {q_q[NW-2:0], 1'b1};
      end else begin
        r_d = trial[DW-1:0];
        q_d = {q_q[NW-2:0], 1'b0};
      end
      n_d = n_q - 1'b1;
      if (n_q == CW'(1)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q   <= '0;
      r_q   <= '0;
      n_q   <= '0;
      run_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      q_q   <= q_d;
      r_q   <= r_d;
      n_q   <= n_d;
      run_q <= run_d;
      done  <= done_d;
    end
  end

  assign quot = q_q;
endmodule

// File: rtl/mpc_speed_ctrl.sv
module mpc_speed_ctrl #(
  parameter int W        = 24,
  parameter int F        = 12,
  parameter int HMAX     = 15,
  parameter int A_INIT   = 3850,
  parameter int B_INIT   = 6308,
  parameter int HOR_INIT = 10,
  parameter int U_MAX    = 409600
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic [W-1:0] meas,
  input  logic [W-1:0] ref_spd,
  input  logic         cfg_we,
  input  logic [1:0]   cfg_sel,
  input  logic [W-1:0] cfg_data,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] u_out
);
  import mpc_pkg::*;
  localparam int HW = $clog2(HMAX + 1);
  localparam int PW = 2 * W;
  localparam int NW = PW + F;
  localparam logic signed [PW:0] WMAX = {{(PW-W+2){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [PW:0] WMIN = {{(PW-W+2){1'b1}}, {(W-1){1'b0}}};
  localparam logic signed [PW:0] PMAX = {2'b00, {(PW-1){1'b1}}};
  localparam logic signed [PW:0] PMIN = {2'b11, {(PW-1){1'b0}}};
  localparam logic signed [PW:0] UMX  = (PW+1)'(U_MAX);

  function automatic logic signed [PW:0] sx(input logic signed [W-1:0] v);
    return {{(PW+1-W){v[W-1]}}, v};
  endfunction
  function automatic logic signed [W-1:0] sat_w(input logic signed [PW:0] v);
    if (v > WMAX) return WMAX[W-1:0];
    if (v < WMIN) return WMIN[W-1:0];
    return v[W-1:0];
  endfunction
  function automatic logic signed [PW-1:0] sat_p(input logic signed [PW:0] v);
    if (v > PMAX) return PMAX[PW-1:0];
    if (v < PMIN) return PMIN[PW-1:0];
    return v[PW-1:0];
  endfunction

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  mpc_state_e st_q, st_d;
  logic signed [W-1:0]  x_q, x_d, u_q, u_d, d_q, d_d, bu_q, bu_d;
  logic signed [W-1:0]  xf_q, xf_d, g_q, g_d, ref_q, ref_d, meas_q, meas_d;
  logic signed [PW-1:0] num_q, num_d, den_q, den_d;
  logic [HW-1:0]        k_q, k_d;

  logic signed [W-1:0]  coef_a, coef_b, op_a, op_b, addend, lin_w, yp, err;
  logic [HW-1:0]        hor;
  logic signed [PW-1:0] prod, prod_sh, acc_src, acc_sat;
  logic signed [PW:0]   lin;
  logic                 take, div_start, div_done;
  logic [PW-1:0]        num_mag;
  logic [NW-1:0]        quot;
  logic signed [W-1:0]  q_lim;
  logic signed [PW:0]   u_sum;

  assign busy = (st_q != ST_IDLE) && (st_q != ST_OUT);
  assign done = (st_q == ST_OUT);
  assign take = strobe && !busy;

  mpc_cfg #(.W(W), .HW(HW), .A_INIT(A_INIT), .B_INIT(B_INIT), .HOR_INIT(HOR_INIT)) u_cfg (
    .clk(clk), .rst_n(rst_i), .we(cfg_we && !busy), .sel(cfg_sel), .data(cfg_data),
    .coef_a(coef_a), .coef_b(coef_b), .hor(hor)
  );

  // one shared multiplier, operands picked by the sequencer
  always_comb begin
    op_a   = coef_a;
    op_b   = '0;
    addend = '0;
    case (st_q)
      ST_BU: begin op_a = coef_b; op_b = u_q; end
      ST_X:  begin op_b = x_q;  addend = bu_q; end
      ST_XF: begin op_b = xf_q; addend = bu_q; end
      ST_G:  begin op_b = g_q;  addend = coef_b; end
      ST_GE: begin op_a = g_q;  op_b = err; end
      ST_GG: begin op_a = g_q;  op_b = g_q; end
      default: ;
    endcase
  end

  mpc_qmul #(.W(W)) u_mul (.op_a(op_a), .op_b(op_b), .prod(prod));

  assign prod_sh = prod >>> F;
  assign lin     = {prod_sh[PW-1], prod_sh} + sx(addend);
  assign lin_w   = sat_w(lin);
  assign yp      = sat_w(sx(xf_q) + sx(d_q));
  assign err     = sat_w(sx(ref_q) - sx(yp));
  assign acc_src = (st_q == ST_GE) ? num_q : den_q;
  assign acc_sat = sat_p({acc_src[PW-1], acc_src} + {prod[PW-1], prod});

  assign num_mag = num_q[PW-1] ? (~num_q + 1'b1) : num_q;
  mpc_divider #(.NW(NW), .DW(PW)) u_div (
    .clk(clk), .rst_n(rst_i), .start(div_start), .dividend({num_mag, {F{1'b0}}}),
    .divisor(den_q), .quot(quot), .done(div_done)
  );

  assign q_lim = (|quot[NW-1:W-1]) ? WMAX[W-1:0] : {1'b0, quot[W-2:0]};
  assign u_sum = sx(u_q) + (num_q[PW-1] ? -sx(q_lim) : sx(q_lim));

  always_comb begin
    st_d = st_q; x_d = x_q; u_d = u_q; d_d = d_q; bu_d = bu_q;
    xf_d = xf_q; g_d = g_q; num_d = num_q; den_d = den_q; k_d = k_q;
    ref_d = ref_q; meas_d = meas_q; div_start = 1'b0;
    case (st_q)
      ST_IDLE, ST_OUT: begin
        st_d = ST_IDLE;
        if (take) begin
          ref_d = ref_spd; meas_d = meas; st_d = ST_BU;
        end
      end
      ST_BU: begin bu_d = lin_w; st_d = ST_X; end
      ST_X: begin
        x_d = lin_w; xf_d = lin_w; d_d = sat_w(sx(meas_q) - sx(lin_w));
        g_d = '0; num_d = '0; den_d = '0; k_d = '0;
        st_d = (hor == '0) ? ST_CHK : ST_XF;
      end
      ST_XF: begin xf_d = lin_w; st_d = ST_G; end
      ST_G:  begin g_d = lin_w;  st_d = ST_GE; end
      ST_GE: begin num_d = acc_sat; st_d = ST_GG; end
      ST_GG: begin
        den_d = acc_sat; k_d = k_q + 1'b1;
        st_d = (k_q + 1'b1 == hor) ? ST_CHK : ST_XF;
      end
      ST_CHK: begin
        if (den_q == '0) st_d = ST_OUT;
        else begin div_start = 1'b1; st_d = ST_DIV; end
      end
      ST_DIV: begin
        if (div_done) begin
          if (u_sum < 0)        u_d = '0;
          else if (u_sum > UMX) u_d = UMX[W-1:0];
          else                  u_d = u_sum[W-1:0];
          st_d = ST_OUT;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q <= ST_IDLE; x_q <= '0; u_q <= '0; d_q <= '0; bu_q <= '0;
      xf_q <= '0; g_q <= '0; num_q <= '0; den_q <= '0; k_q <= '0;
      ref_q <= '0; meas_q <= '0;
    end else begin
      st_q <= st_d; x_q <= x_d; u_q <= u_d; d_q <= d_d; bu_q <= bu_d;
      xf_q <= xf_d; g_q <= g_d; num_q <= num_d; den_q <= den_d; k_q <= k_d;
      ref_q <= ref_d; meas_q <= meas_d;
    end
  end

  assign u_out = u_q;
endmodule

// File: rtl/mpc_speed_chk.sv
module mpc_speed_chk #(
  parameter int W     = 24,
  parameter int U_MAX = 409600,
  parameter int LAT   = 128
) (
  input logic         clk,
  input logic         rst_n,
  input logic         strobe,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] u_out
);
  logic [15:0] cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (busy) cnt_q <= cnt_q + 1'b1;
    else           cnt_q <= '0;
  end

  p_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !u_out[W-1] && (u_out <= W'(U_MAX)));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(u_out));
  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  p_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(strobe));
  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q < 16'(LAT)));
endmodule

bind mpc_speed_ctrl mpc_speed_chk #(.W(W), .U_MAX(U_MAX), .LAT(8 + 4*HMAX + 2*W + F)) u_chk (
  .clk(clk), .rst_n(rst_n), .strobe(strobe), .busy(busy), .done(done), .u_out(u_out)
);

// File: tb/sim_mpc_speed_ctrl.sv
module sim_mpc_speed_ctrl;
  localparam int CLK_NS = 10;
  localparam int W = 24;
  localparam int F = 12;
  localparam int UMAX = 409600;
  localparam longint WMX = (64'sd1 <<< (W-1)) - 1;
  localparam longint WMN = -(64'sd1 <<< (W-1));
  localparam longint PMX = (64'sd1 <<< (2*W-1)) - 1;
  localparam longint PMN = -(64'sd1 <<< (2*W-1));

  logic clk = 1'b0;
  logic rst_n, strobe, cfg_we, busy, done;
  logic [W-1:0] meas, ref_spd, cfg_data, u_out;
  logic [1:0] cfg_sel;
  int total = 0, fails = 0;
  longint m_x, m_u, m_a, m_b, m_n;

  always #(CLK_NS/2) clk = ~clk;

  mpc_speed_ctrl u0 (.clk(clk), .rst_n(rst_n), .strobe(strobe), .meas(meas), .ref_spd(ref_spd),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data), .busy(busy), .done(done), .u_out(u_out));

  function automatic longint satw(longint v);
    return (v > WMX) ? WMX : (v < WMN) ? WMN : v;
  endfunction
  function automatic longint satp(longint v);
    return (v > PMX) ? PMX : (v < PMN) ? PMN : v;
  endfunction
  function automatic longint mq(longint p, longint q);
    return (p * q) >>> F;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_step(input longint r, input longint y);
    longint bu, xf, g, e, d, num, den, mag, q, un;
    bu = satw(mq(m_b, m_u));
    m_x = satw(mq(m_a, m_x) + bu);
    d = satw(y - m_x);
    xf = m_x; g = 0; num = 0; den = 0;
    for (int k = 0; k < m_n; k++) begin
      xf = satw(mq(m_a, xf) + bu);
      g = satw(mq(m_a, g) + m_b);
      e = satw(r - satw(xf + d));
      num = satp(num + g * e);
      den = satp(den + g * g);
    end
    if (den != 0) begin
      mag = (num < 0) ? -num : num;
      q = (mag <<< F) / den;
      if (q > WMX) q = WMX;
      un = m_u + ((num < 0) ? -q : q);
      if (un < 0) un = 0;
      if (un > UMAX) un = UMAX;
      m_u = un;
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input longint v, input bit apply);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = v[W-1:0];
    @(negedge clk);
    cfg_we = 1'b0;
    if (apply) begin
      if (sel == 2'd0) m_a = v;
      if (sel == 2'd1) m_b = v;
      if (sel == 2'd2) m_n = v & 15;
    end
  endtask

  task automatic start(input longint r, input longint y);
    strobe = 1'b1; ref_spd = r[W-1:0]; meas = y[W-1:0];
    @(negedge clk);
    strobe = 1'b0;
  endtask

  task automatic finish(output int cyc, output bit busy_bad);
    cyc = 1; busy_bad = 0;
    while (!done && cyc < 2000) begin
      if (!busy) busy_bad = 1;
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run(input longint r, input longint y, input string req);
    int cyc; bit bb; longint bound;
    start(r, y);
    finish(cyc, bb);
    model_step(r, y);
    chk(longint'($signed(u_out)) == m_u, req, longint'($signed(u_out)), m_u);
    bound = 8 + 4 * m_n + 2 * W + F;
    chk(cyc <= bound && !bb, "R10 latency/busy", cyc, bound);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int cyc; bit bb; int extra; longint u_before;
    rst_n = 1'b0; strobe = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_data = '0;
    meas = '0; ref_spd = '0;
    m_x = 0; m_u = 0; m_a = 3850; m_b = 6308; m_n = 10;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(u_out == '0, "R1 reset u_out", longint'(u_out), 0);
    chk(!busy, "R1 reset busy", longint'(busy), 0);
    chk(!done, "R1 reset done", longint'(done), 0);

    // R2 R3 R4 R7: defaults, swept setpoints and measurements, state carried
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        run((i - 2) * 20000, (j - 3) * 15000, "R2 R3 R4 sweep");

    // R5: clamp at top and bottom of the duty range
    run(WMX, WMN, "R5 clamp high");
    chk(longint'(u_out) == UMAX, "R5 top value", longint'(u_out), UMAX);
    run(WMN, WMX, "R5 clamp low");
    chk(u_out == '0, "R5 bottom value", longint'(u_out), 0);

    // R7: horizon lengths
    cfg_write(2'd2, 1, 1);
    for (int i = 0; i < 4; i++) run(30000 + i * 9000, i * 7000, "R7 horizon 1");
    cfg_write(2'd2, 15, 1);
    for (int i = 0; i < 4; i++) run(60000 - i * 11000, i * 5000, "R7 horizon 15");
    cfg_write(2'd3, 0, 0);
    run(50000, 12000, "R7 reserved select");

    // R8: pole near 2 drives the sums to their limits
    cfg_write(2'd0, 8191, 1);
    cfg_write(2'd1, 8000000, 1);
    run(WMX, WMN, "R8 accumulator saturation");
    run(WMN, WMX, "R8 accumulator saturation neg");
    cfg_write(2'd0, 3850, 1);
    cfg_write(2'd1, 6308, 1);
    cfg_write(2'd2, 10, 1);
    run(80000, 10000, "R8 recovery");

    // R6: zero gain and zero horizon keep the drive
    cfg_write(2'd1, 0, 1);
    u_before = m_u;
    run(90000, 0, "R6 zero gain");
    chk(longint'(u_out) == u_before, "R6 gain held", longint'(u_out), u_before);
    cfg_write(2'd1, 6308, 1);
    cfg_write(2'd2, 0, 1);
    u_before = m_u;
    run(-70000, 40000, "R6 zero horizon");
    chk(longint'(u_out) == u_before, "R6 horizon held", longint'(u_out), u_before);
    cfg_write(2'd2, 10, 1);
    run(70000, 20000, "R6 after restore");

    // R9: strobe and write during a run are ignored
    start(100000, 5000);
    repeat (3) @(negedge clk);
    strobe = 1'b1; ref_spd = W'(-100000); meas = W'(90000);
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_data = '0;
    @(negedge clk);
    strobe = 1'b0; cfg_we = 1'b0;
    finish(cyc, bb);
    model_step(100000, 5000);
    chk(longint'($signed(u_out)) == m_u, "R9 busy strobe ignored", longint'($signed(u_out)), m_u);
    extra = 0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk(extra == 0, "R9 no second result", extra, 0);
    run(20000, 60000, "R9 busy write ignored");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule